// File: doc/BRIEF.md
# Scaled Displacement Operand Decoder

This block turns an operand specifier into a ready-to-use operand descriptor. A request carries a two-bit addressing type, a register index, a size form and a size code. Some addressing types need a displacement. For those, the block pulls one or two extra instruction bytes from a byte-serial stream that uses a valid/ready handshake. The displacement is counted in units of the operand size, so the block scales it to a byte offset before presenting it.

The descriptor it produces gives the operand kind (a direct register, or memory through a base register), the base register, the scaled addend and a size tag. The descriptor appears on registered outputs together with a one-cycle done pulse. The block does not add the address, access memory or recognise opcodes. A decode front end issues one request per operand and waits for done before it issues the next.

Three size forms are supported:
- **Plain:** a byte/word/long code whose signedness does not matter.
- **Extended memory:** a code that also carries signed and unsigned byte and word variants.
- **Fixed:** an unsigned-byte form that becomes long for direct register operands.

Top module: `scaled_disp_decoder`

## Requirements
- R1: Type 3 yields `kind_o=0` (register), `base_o` set to the requested register and `addend_o=0`. It consumes no stream bytes, and `done_o` is high in the cycle after the request is accepted.
- R2: Type 0 yields `kind_o=1` (indirect) with `addend_o=0`. It consumes no stream bytes, and `done_o` is high in the cycle after the request is accepted.
- R3: Type 1 consumes one stream byte, treated as an unsigned displacement, and yields `kind_o=1`. `done_o` is high in the cycle after that byte is accepted.
- R4: Type 2 consumes two stream bytes, the first being the low half of an unsigned 16-bit displacement and the second the high half. `done_o` is high in the cycle after the second byte is accepted.
- R5: The addend is the displacement times 1 for byte sizes, times 2 for word sizes and times 4 for long. It is 18 bits wide, so 0xFFFF with a long size gives 0x3FFFC without loss.
- R6: Size tag encoding on `size_o` is: 0 byte, 1 signed byte, 2 unsigned byte, 3 word, 4 signed word, 5 unsigned word, 6 long. With form 0 (plain), code 0 gives byte, code 1 gives word, and codes 2 and 3 give long.
- R7: With form 1 (extended memory), code 0 gives signed byte, 1 gives signed word, 2 gives long and 3 gives unsigned word.
- R8: With form 2 or 3 (fixed), the size is unsigned byte, or long when the type is 3. The size code is ignored.
- R9: `byte_ready_o` is high only while displacement bytes are awaited. A byte offered at any other time is not consumed and does not change the result.
- R10: `req_ready_o` is high only when no request is in progress. A request offered while busy is ignored and produces no descriptor.
- R11: A synchronous reset, including one in the middle of a fetch, returns the block to idle and clears `done_o` and the descriptor outputs.
- R12: `done_o` is a one-cycle pulse, and the descriptor outputs hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Operand request offered |
| req_ready_o | output | 1 | Block idle, request accepted this cycle if valid |
| req_type_i | input | 2 | Addressing type code (0 indirect, 1 disp8, 2 disp16, 3 register) |
| req_reg_i | input | REG_W | Register index |
| req_form_i | input | 2 | Size form (0 plain, 1 extended memory, 2/3 fixed) |
| req_code_i | input | 2 | Size code interpreted by the form |
| byte_valid_i | input | 1 | Stream byte offered |
| byte_ready_o | output | 1 | Stream byte wanted |
| byte_data_i | input | BYTE_W | Stream byte |
| done_o | output | 1 | Descriptor valid pulse |
| kind_o | output | 1 | 0 register, 1 indirect |
| base_o | output | REG_W | Base or direct register |
| addend_o | output | ADDEND_W | Scaled displacement |
| size_o | output | 3 | Operand size tag |

## Verification
The bench goes after the byte order of the 16-bit displacement. A swapped assembly turns 0x1234 into 0x3412.

It drives the all-ones displacement with a long size. An addend that is too narrow, or a shift applied before widening, would drop the top bits of 0x3FFFC.

It covers every size code in every form. A mapping that confuses signed and unsigned word, or that honours the code in the fixed form, shows up as a wrong size tag or a wrong multiplier.

It offers stray stream bytes while idle, presents a second request while a fetch is under way, and resets in the middle of a fetch. A design that swallowed the stray byte would report its value, one that accepted the overlapping request would emit an unexpected descriptor, and one that kept a stale state would take the next byte as a high half.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

  // addressing type codes (decoded by neighbours, values fixed)
  localparam logic [1:0] AM_IND   = 2'd0;
  localparam logic [1:0] AM_DISP8 = 2'd1;
  localparam logic [1:0] AM_DISP16 = 2'd2;
  localparam logic [1:0] AM_REG   = 2'd3;

  // size forms
  localparam logic [1:0] FORM_PLAIN = 2'd0;
  localparam logic [1:0] FORM_EXT   = 2'd1;

  // size tags
  localparam logic [2:0] OSZ_BYTE  = 3'd0;
  localparam logic [2:0] OSZ_SBYTE = 3'd1;
  localparam logic [2:0] OSZ_UBYTE = 3'd2;
  localparam logic [2:0] OSZ_WORD  = 3'd3;
  localparam logic [2:0] OSZ_SWORD = 3'd4;
  localparam logic [2:0] OSZ_UWORD = 3'd5;
  localparam logic [2:0] OSZ_LONG  = 3'd6;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_LO   = 2'd1,
    F_HI   = 2'd2
  } fetch_state_e;

  function automatic logic [1:0] size_shift(input logic [2:0] sz);
    case (sz)
      OSZ_WORD, OSZ_SWORD, OSZ_UWORD: size_shift = 2'd1;
      OSZ_LONG:                       size_shift = 2'd2;
      default:                        size_shift = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/opdec_size_map.sv
module opdec_size_map
  import opdec_pkg::*;
(
  input  logic [1:0] form_i,
  input  logic [1:0] code_i,
  input  logic [1:0] amode_i,
  output logic [2:0] size_o,
  output logic [1:0] shift_o
);

  always_comb begin
    case (form_i)
      FORM_PLAIN: begin
        case (code_i)
          2'd0:    size_o = OSZ_BYTE;
          2'd1:    size_o = OSZ_WORD;
          default: size_o = OSZ_LONG;
        endcase
      end
      FORM_EXT: begin
        case (code_i)
          2'd0:    size_o = OSZ_SBYTE;
          2'd1:    size_o = OSZ_SWORD;
          2'd2:    size_o = OSZ_LONG;
          default: size_o = OSZ_UWORD;
        endcase
      end
      default: size_o = (amode_i == AM_REG) ? OSZ_LONG : OSZ_UBYTE;
    endcase
    shift_o = size_shift(size_o);
  end

endmodule

// File: rtl/opdec_fetch.sv
module opdec_fetch
  import opdec_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [1:0]            nbytes_i,
  input  logic                  byte_valid_i,
  input  logic [BYTE_W-1:0]     byte_data_i,
  output logic                  idle_o,
  output logic                  byte_ready_o,
  output logic                  finish_o,
  output logic [2*BYTE_W-1:0]   disp_o
);

  localparam int DISP_W = 2 * BYTE_W;

  fetch_state_e      state_q;
  logic              need2_q;
  logic [BYTE_W-1:0] lo_q;
  logic              accept;

  always_comb begin
    idle_o       = (state_q == F_IDLE);
    byte_ready_o = !idle_o;
    accept       = byte_ready_o && byte_valid_i;
    finish_o     = (idle_o && start_i && (nbytes_i == 2'd0)) ||
                   ((state_q == F_LO) && accept && !need2_q) ||
                   ((state_q == F_HI) && accept);
    case (state_q)
      F_LO:    disp_o = {{BYTE_W{1'b0}}, byte_data_i};
      F_HI:    disp_o = {byte_data_i, lo_q};
      default: disp_o = {DISP_W{1'b0}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= F_IDLE;
      need2_q <= 1'b0;
      lo_q    <= '0;
    end else begin
      case (state_q)
        F_IDLE: begin
          if (start_i && (nbytes_i != 2'd0)) begin
            state_q <= F_LO;
            need2_q <= nbytes_i[1];
          end
        end
        F_LO: begin
          if (accept) begin
            lo_q    <= byte_data_i;
            state_q <= need2_q ? F_HI : F_IDLE;
          end
        end
        F_HI: begin
          if (accept) state_q <= F_IDLE;
        end
        default: state_q <= F_IDLE;
      endcase
    end
  end

  // R4
  hi_after_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == F_HI) |-> ($past(state_q) == F_LO || $past(state_q) == F_HI));

  // R9
  no_byte_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_o && byte_valid_i && !start_i) |=> (state_q == F_IDLE));

endmodule

// File: rtl/opdec_scaler.sv
module opdec_scaler #(
  parameter int DISP_W   = 16,
  parameter int ADDEND_W = 18
) (
  input  logic [DISP_W-1:0]   disp_i,
  input  logic [1:0]          shift_i,
  output logic [ADDEND_W-1:0] addend_o
);

  logic [ADDEND_W-1:0] wide;

  always_comb begin
    wide = ADDEND_W'(disp_i);
    case (shift_i)
      2'd1:    addend_o = wide << 1;
      2'd2:    addend_o = wide << 2;
      default: addend_o = wide;
    endcase
  end

endmodule

// File: rtl/scaled_disp_decoder.sv
module scaled_disp_decoder
  import opdec_pkg::*;
#(
  parameter int REG_W    = 4,
  parameter int BYTE_W   = 8,
  parameter int ADDEND_W = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [1:0]          req_type_i,
  input  logic [REG_W-1:0]    req_reg_i,
  input  logic [1:0]          req_form_i,
  input  logic [1:0]          req_code_i,
  input  logic                byte_valid_i,
  output logic                byte_ready_o,
  input  logic [BYTE_W-1:0]   byte_data_i,
  output logic                done_o,
  output logic                kind_o,
  output logic [REG_W-1:0]    base_o,
  output logic [ADDEND_W-1:0] addend_o,
  output logic [2:0]          size_o
);

  localparam int DISP_W = 2 * BYTE_W;

  logic              idle, start, finish;
  logic [1:0]        nbytes;
  logic [DISP_W-1:0] disp;
  logic [1:0]        type_q, form_q, code_q;
  logic [REG_W-1:0]  reg_q;
  logic [1:0]        cur_type, cur_form, cur_code;
  logic [REG_W-1:0]  cur_reg;
  logic [2:0]        cur_size;
  logic [1:0]        cur_shift;
  logic [ADDEND_W-1:0] scaled;

  always_comb begin
    start       = req_valid_i && idle;
    req_ready_o = idle;
    case (req_type_i)
      AM_DISP8:  nbytes = 2'd1;
      AM_DISP16: nbytes = 2'd2;
      default:   nbytes = 2'd0;
    endcase
    cur_type = idle ? req_type_i : type_q;
    cur_reg  = idle ? req_reg_i  : reg_q;
    cur_form = idle ? req_form_i : form_q;
    cur_code = idle ? req_code_i : code_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q <= AM_IND;
      reg_q  <= '0;
      form_q <= FORM_PLAIN;
      code_q <= 2'd0;
    end else if (start) begin
      type_q <= req_type_i;
      reg_q  <= req_reg_i;
      form_q <= req_form_i;
      code_q <= req_code_i;
    end
  end

  opdec_fetch #(.BYTE_W(BYTE_W)) u_fetch (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start),
    .nbytes_i     (nbytes),
    .byte_valid_i (byte_valid_i),
    .byte_data_i  (byte_data_i),
    .idle_o       (idle),
    .byte_ready_o (byte_ready_o),
    .finish_o     (finish),
    .disp_o       (disp)
  );

  opdec_size_map u_size (
    .form_i  (cur_form),
    .code_i  (cur_code),
    .amode_i (cur_type),
    .size_o  (cur_size),
    .shift_o (cur_shift)
  );

  opdec_scaler #(.DISP_W(DISP_W), .ADDEND_W(ADDEND_W)) u_scale (
    .disp_i   (disp),
    .shift_i  (cur_shift),
    .addend_o (scaled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o   <= 1'b0;
      kind_o   <= 1'b0;
      base_o   <= '0;
      addend_o <= '0;
      size_o   <= OSZ_BYTE;
    end else begin
      done_o <= finish;
      if (finish) begin
        kind_o   <= (cur_type != AM_REG);
        base_o   <= cur_reg;
        addend_o <= scaled;
        size_o   <= cur_size;
      end
    end
  end

  // R10
  one_side_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_ready_o && byte_ready_o));

  // R1
  reg_zero_addend_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !kind_o) |-> (addend_o == '0));

  // R5
  long_align_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && size_o == OSZ_LONG) |-> (addend_o[1:0] == 2'b00));

  // R5
  byte_range_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && (size_o == OSZ_BYTE || size_o == OSZ_SBYTE || size_o == OSZ_UBYTE))
      |-> (addend_o[ADDEND_W-1:DISP_W] == '0));

  // R12
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    (!done_o && !$past(rst)) |-> ($stable(addend_o) && $stable(base_o) && $stable(size_o)));

endmodule

// File: tb/tb_scaled_disp_decoder.sv
module tb_scaled_disp_decoder;

  localparam int REG_W = 4;
  localparam int AW    = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_type = 2'd0, req_form = 2'd0, req_code = 2'd0;
  logic [REG_W-1:0] req_reg = '0;
  logic byte_valid = 1'b0;
  logic byte_ready;
  logic [7:0] byte_data = 8'h00;
  logic done, kind;
  logic [REG_W-1:0] base;
  logic [AW-1:0] addend;
  logic [2:0] size;

  always #10 clk = ~clk;

  scaled_disp_decoder dut (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_type_i(req_type), .req_reg_i(req_reg),
    .req_form_i(req_form), .req_code_i(req_code),
    .byte_valid_i(byte_valid), .byte_ready_o(byte_ready), .byte_data_i(byte_data),
    .done_o(done), .kind_o(kind), .base_o(base), .addend_o(addend), .size_o(size)
  );

  typedef struct {
    logic           kind;
    logic [3:0]     base;
    logic [AW-1:0]  addend;
    logic [2:0]     size;
    string          tag;
  } exp_t;

  exp_t sb[$];
  int n_checks = 0;
  int n_fail = 0;
  bit reported = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic logic [2:0] exp_size(input logic [1:0] f, input logic [1:0] c, input logic [1:0] t);
    if (f == 2'd0) return (c == 2'd0) ? 3'd0 : (c == 2'd1) ? 3'd3 : 3'd6;
    if (f == 2'd1) begin
      case (c)
        2'd0: return 3'd1;
        2'd1: return 3'd4;
        2'd2: return 3'd6;
        default: return 3'd5;
      endcase
    end
    return (t == 2'd3) ? 3'd6 : 3'd2;
  endfunction

  function automatic int exp_mult(input logic [2:0] s);
    if (s == 3'd6) return 4;
    if (s >= 3'd3) return 2;
    return 1;
  endfunction

  // monitor: compare every completion against the scoreboard
  always begin
    @(posedge clk);
    #2;
    if (!rst && done) begin
      if (sb.size() == 0) begin
        chk(0, "R10 unexpected descriptor", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(kind == e.kind, {e.tag, " kind"}, kind, e.kind);
        chk(base == e.base, {e.tag, " base"}, base, e.base);
        chk(addend == e.addend, {e.tag, " addend"}, addend, e.addend);
        chk(size == e.size, {e.tag, " size"}, size, e.size);
      end
    end
  end

  task automatic push_exp(input logic [1:0] t, input logic [3:0] r, input logic [1:0] f,
                          input logic [1:0] c, input logic [7:0] lo, input logic [7:0] hi,
                          input string tag);
    exp_t e;
    logic [15:0] d;
    e.size = exp_size(f, c, t);
    d = (t == 2'd1) ? {8'h00, lo} : (t == 2'd2) ? {hi, lo} : 16'h0000;
    e.kind = (t != 2'd3);
    e.base = r;
    e.addend = AW'(d) * AW'(exp_mult(e.size));
    e.tag = tag;
    sb.push_back(e);
  endtask

  // driver: one full operand decode
  task automatic do_op(input logic [1:0] t, input logic [3:0] r, input logic [1:0] f,
                       input logic [1:0] c, input logic [7:0] lo, input logic [7:0] hi,
                       input int gap, input string tag);
    push_exp(t, r, f, c, lo, hi, tag);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_type = t; req_reg = r; req_form = f; req_code = c;
    @(posedge clk); #2;
    if (t == 2'd0 || t == 2'd3) begin
      chk(done == 1'b1, {tag, " done timing (R1/R2)"}, done, 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(byte_ready == 1'b0, "R1 no bytes wanted", byte_ready, 0);
    end else begin
      chk(done == 1'b0, {tag, " no early done"}, done, 0);
      @(negedge clk);
      req_valid = 1'b0;
      for (int g = 0; g < gap; g++) begin
        chk(byte_ready == 1'b1, "R9 ready while waiting", byte_ready, 1);
        @(negedge clk);
      end
      chk(byte_ready == 1'b1, "R9 ready while waiting", byte_ready, 1);
      byte_valid = 1'b1; byte_data = lo;
      @(posedge clk); #2;
      if (t == 2'd1) begin
        chk(done == 1'b1, {tag, " done after byte (R3)"}, done, 1);
      end else begin
        chk(done == 1'b0, {tag, " no done after low byte (R4)"}, done, 0);
        @(negedge clk);
        byte_data = hi;
        @(posedge clk); #2;
        chk(done == 1'b1, {tag, " done after high byte (R4)"}, done, 1);
      end
      @(negedge clk);
      byte_valid = 1'b0;
    end
    @(posedge clk); #2;
    chk(done == 1'b0, "R12 done is a pulse", done, 0);
  endtask

  initial begin
    #(20 * 200000);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R11 reset state
    chk(done == 1'b0, "R11 reset done", done, 0);
    chk(addend == '0, "R11 reset addend", addend, 0);
    chk(req_ready == 1'b1, "R11 reset idle", req_ready, 1);
    chk(byte_ready == 1'b0, "R11 reset no byte wanted", byte_ready, 0);
    @(negedge clk);
    rst = 1'b0;

    do_op(2'd3, 4'd7, 2'd0, 2'd1, 8'h00, 8'h00, 0, "R1 register plain word");
    do_op(2'd0, 4'd2, 2'd1, 2'd3, 8'h00, 8'h00, 0, "R2 indirect ext uword");
    do_op(2'd1, 4'd1, 2'd0, 2'd0, 8'hAB, 8'h00, 0, "R3 disp8 byte");
    do_op(2'd1, 4'd3, 2'd0, 2'd1, 8'h80, 8'h00, 2, "R5 disp8 word");
    do_op(2'd2, 4'd15, 2'd0, 2'd2, 8'hFF, 8'hFF, 0, "R5 disp16 long max");
    do_op(2'd2, 4'd4, 2'd1, 2'd0, 8'h34, 8'h12, 1, "R4 disp16 order sbyte");
    do_op(2'd1, 4'd5, 2'd1, 2'd1, 8'h7F, 8'h00, 0, "R7 ext sword");
    do_op(2'd1, 4'd6, 2'd1, 2'd2, 8'h10, 8'h00, 0, "R7 ext long");
    do_op(2'd1, 4'd8, 2'd2, 2'd2, 8'h40, 8'h00, 0, "R8 fixed ubyte ignores code");
    do_op(2'd3, 4'd9, 2'd3, 2'd0, 8'h00, 8'h00, 0, "R8 fixed register long");
    do_op(2'd2, 4'd0, 2'd0, 2'd3, 8'h01, 8'h00, 0, "R6 plain code3 long");

    // sweep all forms and codes with two-byte displacement
    for (int f = 0; f < 4; f++)
      for (int c = 0; c < 4; c++)
        do_op(2'd2, 4'(f * 4 + c), 2'(f), 2'(c), 8'(8'h11 * c + 1), 8'(8'h21 * f + 3), 0,
              "R6 R7 R8 size sweep");

    // R9 stray byte while idle is ignored
    @(negedge clk);
    byte_valid = 1'b1; byte_data = 8'h55;
    @(posedge clk); #2;
    chk(byte_ready == 1'b0, "R9 stray byte not wanted", byte_ready, 0);
    chk(done == 1'b0, "R9 stray byte no descriptor", done, 0);
    @(negedge clk);
    byte_valid = 1'b0;
    do_op(2'd1, 4'd10, 2'd0, 2'd0, 8'h11, 8'h00, 0, "R9 result after stray byte");

    // R10 request while busy is ignored
    push_exp(2'd2, 4'd5, 2'd0, 2'd1, 8'h02, 8'h01, "R10 first request kept");
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'd2; req_reg = 4'd5; req_form = 2'd0; req_code = 2'd1;
    @(negedge clk);
    req_type = 2'd3; req_reg = 4'd9; req_form = 2'd2;
    chk(req_ready == 1'b0, "R10 not ready while busy", req_ready, 0);
    byte_valid = 1'b1; byte_data = 8'h02;
    @(negedge clk);
    req_valid = 1'b0;
    byte_data = 8'h01;
    @(negedge clk);
    byte_valid = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    chk(sb.size() == 0, "R10 scoreboard drained", sb.size(), 0);

    // R11 reset in the middle of a fetch
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'd2; req_reg = 4'd3; req_form = 2'd0; req_code = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    byte_valid = 1'b1; byte_data = 8'hEE;
    @(negedge clk);
    byte_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk); #2;
    chk(done == 1'b0, "R11 mid reset done", done, 0);
    chk(addend == '0, "R11 mid reset addend", addend, 0);
    chk(byte_ready == 1'b0, "R11 mid reset idle", byte_ready, 0);
    @(negedge clk);
    rst = 1'b0;
    do_op(2'd1, 4'd12, 2'd0, 2'd2, 8'h21, 8'h00, 0, "R11 clean after reset");
    // R12 hold
    repeat (3) @(posedge clk);
    #2;
    chk(addend == AW'(18'h84), "R12 addend held", addend, 18'h84);
    chk(base == 4'd12, "R12 base held", base, 12);

    report();
  end

endmodule